// File: doc/BRIEF.md
# Configurable Parallel CRC Engine (16/32-bit)

This block keeps a running cyclic redundancy check over a stream of data words and absorbs one whole word on every clock edge where the input strobe is high. A mode input selects the CRC width. In 16-bit mode it uses the CCITT generator 0x1021. In 32-bit mode it uses the Ethernet generator 0x04C11DB7. A second input selects the order in which each word's bits are fed in, either most significant bit first or least significant bit first.

Software or a controlling state machine starts a calculation by writing a starting value through the preset port and pulsing the load strobe. It then streams words in with the valid strobe. The running remainder on `crc_o` can be read at any time. The engine applies no final inversion, so a caller that needs a standard checksum applies its own output XOR.

Top module: `crc_engine`

## Requirements
- R1: With `mode32_i`=0 and `lsb_first_i`=0, the register is updated with the generator 0x1021, most significant data bit first. With preset 0xFFFF and the bytes 0x31..0x39 ("123456789"), the result is 0x29B1. With preset 0x0000 and the same bytes, the result is 0x31C3.
- R2: With `mode32_i`=1 and `lsb_first_i`=0, the generator is 0x04C11DB7, most significant bit first. With preset 0xFFFFFFFF and "123456789", the result is 0x0376E6E7.
- R3: A word presented with `data_vld_i`=1 is absorbed in full at the next rising edge, and the new value shows on `crc_o` right after that edge. From zero, the byte 0x01 gives 0x04C11DB7 in 32-bit MSB-first mode.
- R4: No output XOR is applied, so `crc_o` shows the raw remainder, as the values in R1, R2 and R9 show.
- R5: A clock edge with `preset_ld_i`=1 writes `preset_i` into the register. In 16-bit mode only the low 16 bits are written.
- R6: When `preset_ld_i` and `data_vld_i` are both 1 at the same edge, the preset load wins and the data word is discarded.
- R7: At an edge with neither strobe high, the register keeps its value, whatever `data_i` holds.
- R8: In 16-bit mode (`mode32_i`=0), `crc_o[31:16]` reads as zero.
- R9: With `lsb_first_i`=1, data bits are taken bit 0 first, using the reflected generator (0x8408 or 0xEDB88320) and a right shift. The preset and the result are not bit-reversed. With "123456789", the results are 0x6F91 (16-bit, preset 0xFFFF), 0x2189 (16-bit, preset 0) and 0x340BC6D9 (32-bit, preset 0xFFFFFFFF).
- R10: A clock edge with `rst_n`=0 clears the register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode32_i | input | 1 | 1 = 32-bit generator, 0 = 16-bit generator |
| lsb_first_i | input | 1 | 1 = bit 0 of each word first, 0 = top bit first |
| data_i | input | DATA_W | Data word to absorb |
| data_vld_i | input | 1 | Absorb `data_i` at this edge |
| preset_i | input | 32 | Starting value for the register |
| preset_ld_i | input | 1 | Load `preset_i` at this edge |
| crc_o | output | 32 | Current remainder; upper half is zero in 16-bit mode |

## Verification
The bench builds the engine with its default 8-bit word width. That covers the byte-stream check values for all four combinations of width and bit order, and single-byte updates whose results equal the plain or reflected generator. Both presets that matter for these checks, all-zeros and all-ones, are applied. Collisions between load and valid strobes, mode switches while the register holds a value, and a reset in the middle of a run are driven as directed cases.

// File: rtl/crc_pkg.sv
// Shared constants and types for the parallel CRC engine.
// Assumes the register is sized for the widest supported generator.
package crc_pkg;
    localparam int          CRC_MAX_W   = 32;
    localparam int          CRC_NARROW_W = 16;
    localparam logic [15:0] GEN16       = 16'h1021;
    localparam logic [31:0] GEN32       = 32'h04C11DB7;

    typedef enum logic {
        WIDTH_NARROW = 1'b0,
        WIDTH_WIDE   = 1'b1
    } crc_width_e;
endpackage

// File: rtl/crc_step.sv
// Combinational one-word CRC advance for a single generator.
// Computes both bit orders and picks one with lsb_first_i.
// Assumes WIDTH >= 2 and that POLY omits the implicit top term.
module crc_step #(
    parameter int               WIDTH  = 16,
    parameter logic [WIDTH-1:0] POLY   = '0,
    parameter int               DATA_W = 8
) (
    input  logic [WIDTH-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              lsb_first_i,
    output logic [WIDTH-1:0]  crc_o
);
    logic [WIDTH-1:0] poly_ref;
    logic [WIDTH-1:0] fwd_next;
    logic [WIDTH-1:0] rev_next;

    // Mirror the generator for the right-shifting form.
    for (genvar b = 0; b < WIDTH; b++) begin : g_reflect
        assign poly_ref[b] = POLY[WIDTH-1-b];
    end

    // Top bit first: shift left, feed back into the generator taps.
    always_comb begin : p_fwd
        logic [WIDTH-1:0] acc;
        logic             fb;
        acc = crc_i;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[WIDTH-1] ^ data_i[i];
            acc = {acc[WIDTH-2:0], 1'b0} ^ ({WIDTH{fb}} & POLY);
        end
        fwd_next = acc;
    end

    // Bit 0 first: shift right, feed back into the mirrored taps.
    always_comb begin : p_rev
        logic [WIDTH-1:0] acc;
        logic             fb;
        acc = crc_i;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = acc[0] ^ data_i[i];
            acc = {1'b0, acc[WIDTH-1:1]} ^ ({WIDTH{fb}} & poly_ref);
        end
        rev_next = acc;
    end

    // Select the requested bit order.
    always_comb begin : p_sel
        crc_o = lsb_first_i ? rev_next : fwd_next;
    end
endmodule

// File: rtl/crc_state.sv
// Remainder register with synchronous active-low reset.
// A load takes priority over an update; otherwise the value holds.
module crc_state #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         upd_i,
    input  logic [W-1:0] upd_val_i,
    output logic [W-1:0] q_o
);
    // Hold, load or advance the remainder each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= load_val_i;
        else if (upd_i)  q_o <= upd_val_i;
    end
endmodule

// File: rtl/crc_engine.sv
// Parallel CRC engine: 16-bit (0x1021) or 32-bit (0x04C11DB7) generator,
// either bit order, programmable preset, one DATA_W word per clock,
// no output XOR. In narrow mode the upper half of the register is held
// at zero and reads as zero.
module crc_engine
    import crc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode32_i,
    input  logic                 lsb_first_i,
    input  logic [DATA_W-1:0]    data_i,
    input  logic                 data_vld_i,
    input  logic [CRC_MAX_W-1:0] preset_i,
    input  logic                 preset_ld_i,
    output logic [CRC_MAX_W-1:0] crc_o
);
    localparam int PAD_W = CRC_MAX_W - CRC_NARROW_W;

    crc_width_e              width_sel;
    logic [CRC_MAX_W-1:0]    state_q;
    logic [CRC_NARROW_W-1:0] next_narrow;
    logic [CRC_MAX_W-1:0]    next_wide;
    logic [CRC_MAX_W-1:0]    next_word;
    logic [CRC_MAX_W-1:0]    preset_word;

    // Decode the width select into the shared enum.
    always_comb begin
        width_sel = mode32_i ? WIDTH_WIDE : WIDTH_NARROW;
    end

    crc_step #(
        .WIDTH  (CRC_NARROW_W),
        .POLY   (GEN16),
        .DATA_W (DATA_W)
    ) u_step16 (
        .crc_i       (state_q[CRC_NARROW_W-1:0]),
        .data_i      (data_i),
        .lsb_first_i (lsb_first_i),
        .crc_o       (next_narrow)
    );

    crc_step #(
        .WIDTH  (CRC_MAX_W),
        .POLY   (GEN32),
        .DATA_W (DATA_W)
    ) u_step32 (
        .crc_i       (state_q),
        .data_i      (data_i),
        .lsb_first_i (lsb_first_i),
        .crc_o       (next_wide)
    );

    // Pick the next remainder and the preset image for the active width.
    always_comb begin
        if (width_sel == WIDTH_WIDE) begin
            next_word   = next_wide;
            preset_word = preset_i;
        end else begin
            next_word   = {{PAD_W{1'b0}}, next_narrow};
            preset_word = {{PAD_W{1'b0}}, preset_i[CRC_NARROW_W-1:0]};
        end
    end

    crc_state #(
        .W (CRC_MAX_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (preset_ld_i),
        .load_val_i (preset_word),
        .upd_i      (data_vld_i),
        .upd_val_i  (next_word),
        .q_o        (state_q)
    );

    // Present the register, masking the upper half in narrow mode.
    always_comb begin
        crc_o = (width_sel == WIDTH_WIDE) ? state_q
                                          : {{PAD_W{1'b0}}, state_q[CRC_NARROW_W-1:0]};
    end
endmodule

// File: rtl/crc_engine_chk.sv
// Port-level property checker for crc_engine, attached by bind.
module crc_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode32_i,
    input logic              lsb_first_i,
    input logic [DATA_W-1:0] data_i,
    input logic              data_vld_i,
    input logic [31:0]       preset_i,
    input logic              preset_ld_i,
    input logic [31:0]       crc_o
);
    localparam logic [DATA_W-1:0] ONE_LOW  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ONE_HIGH = ONE_LOW << (DATA_W - 1);

    // R7: no strobe and no mode change leaves the output unchanged.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_vld_i && !preset_ld_i) ##1 $stable(mode32_i) |-> $stable(crc_o));

    // R5, R6: a load writes the preset, even when valid is also high.
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_ld_i && mode32_i) ##1 mode32_i |-> crc_o == $past(preset_i));

    // R8: narrow mode shows a zero upper half.
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode32_i |-> crc_o[31:16] == 16'h0);

    // R2, R3: from zero, a lone low bit yields the wide generator in one cycle.
    p_wide_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld_i && !preset_ld_i && mode32_i && !lsb_first_i &&
         crc_o == 32'h0 && data_i == ONE_LOW) ##1 mode32_i
        |-> crc_o == 32'h04C11DB7);

    // R9: from zero, a lone top bit in reflected order yields the mirrored generator.
    p_refl_gen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld_i && !preset_ld_i && mode32_i && lsb_first_i &&
         crc_o == 32'h0 && data_i == ONE_HIGH) ##1 mode32_i
        |-> crc_o == 32'hEDB88320);
endmodule

bind crc_engine crc_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode32_i    (mode32_i),
    .lsb_first_i (lsb_first_i),
    .data_i      (data_i),
    .data_vld_i  (data_vld_i),
    .preset_i    (preset_i),
    .preset_ld_i (preset_ld_i),
    .crc_o       (crc_o)
);

// File: tb/sim_crc_engine.sv
module sim_crc_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode32_i;
    logic        lsb_first_i;
    logic [7:0]  data_i;
    logic        data_vld_i;
    logic [31:0] preset_i;
    logic        preset_ld_i;
    logic [31:0] crc_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    crc_engine #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mode32_i(mode32_i), .lsb_first_i(lsb_first_i),
        .data_i(data_i), .data_vld_i(data_vld_i), .preset_i(preset_i),
        .preset_ld_i(preset_ld_i), .crc_o(crc_o)
    );

    typedef struct packed {
        logic        m32;
        logic        lsb;
        logic [31:0] pre;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Check strings "123456789": width, order, preset, expected, requirement.
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 32'h0000FFFF, 32'h000029B1, 8'd1},
        '{1'b0, 1'b0, 32'h00000000, 32'h000031C3, 8'd1},
        '{1'b1, 1'b0, 32'hFFFFFFFF, 32'h0376E6E7, 8'd2},
        '{1'b0, 1'b1, 32'h0000FFFF, 32'h00006F91, 8'd9},
        '{1'b0, 1'b1, 32'h00000000, 32'h00002189, 8'd9},
        '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h340BC6D9, 8'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: crc_o=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic m32, input logic lsb, input logic [31:0] pre);
        mode32_i = m32; lsb_first_i = lsb; preset_i = pre;
        preset_ld_i = 1'b1; data_vld_i = 1'b0;
        @(negedge clk);
        preset_ld_i = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        data_i = b; data_vld_i = 1'b1;
        @(negedge clk);
        data_vld_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode32_i = 1'b1; lsb_first_i = 1'b0; data_i = 8'hA5;
        data_vld_i = 1'b1; preset_i = 32'hDEADBEEF; preset_ld_i = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 reset clears", crc_o, 32'h0);
        rst_n = 1'b1; data_vld_i = 1'b0;
        @(negedge clk);

        // R1, R2, R4, R9: check strings across widths and orders.
        for (int v = 0; v < 6; v++) begin
            load(VECS[v].m32, VECS[v].lsb, VECS[v].pre);
            for (int k = 0; k < 9; k++) feed(8'h31 + 8'(k));
            check($sformatf("R%0d R4 vector %0d", VECS[v].req, v), crc_o, VECS[v].exp);
        end

        // R3: value changes at the edge that takes the word, not before.
        load(1'b1, 1'b0, 32'h0);
        data_i = 8'h01; data_vld_i = 1'b1;
        #1 check("R3 before edge", crc_o, 32'h0);
        @(negedge clk); data_vld_i = 1'b0;
        check("R3 after one edge", crc_o, 32'h04C11DB7);

        // R1 R9: single-byte generator checks in narrow mode.
        load(1'b0, 1'b0, 32'h0); feed(8'h01);
        check("R1 narrow generator", crc_o, 32'h00001021);
        load(1'b0, 1'b1, 32'h0); feed(8'h80);
        check("R9 narrow mirrored generator", crc_o, 32'h00008408);
        load(1'b1, 1'b1, 32'h0); feed(8'h80);
        check("R9 wide mirrored generator", crc_o, 32'hEDB88320);

        // R5 and R7: loaded value holds while data toggles without valid.
        load(1'b1, 1'b0, 32'h12345678);
        check("R5 preset load", crc_o, 32'h12345678);
        for (int k = 0; k < 4; k++) begin data_i = 8'(k * 37); @(negedge clk); end
        check("R7 hold without valid", crc_o, 32'h12345678);

        // R8: narrow view of a wide value, and narrow preset load.
        mode32_i = 1'b0; #1;
        check("R8 narrow view", crc_o, 32'h00005678);
        mode32_i = 1'b1;
        load(1'b0, 1'b0, 32'hABCD1234);
        check("R8 R5 narrow load", crc_o, 32'h00001234);
        mode32_i = 1'b1; #1;
        check("R8 upper half stored zero", crc_o, 32'h00001234);

        // R6: load and valid together, load wins.
        mode32_i = 1'b1; lsb_first_i = 1'b0; preset_i = 32'h0;
        preset_ld_i = 1'b1; data_vld_i = 1'b1; data_i = 8'hFF;
        @(negedge clk);
        preset_ld_i = 1'b0; data_vld_i = 1'b0;
        check("R6 load beats valid", crc_o, 32'h0);

        // R10: reset in mid-run.
        load(1'b1, 1'b0, 32'hCAFEF00D);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R10 mid-run reset", crc_o, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule